// File: doc/BRIEF.md
# Centre-Aligned PWM Timer Channel

This block is an 8-bit timer channel that counts in both directions to produce a symmetric, centre-aligned pulse-width waveform. A free-running prescaler turns the system clock into a one-cycle count enable. On each enable the counter climbs from zero to a turning value and then falls back to zero. The turning value is either the full 8-bit maximum or a separately written limit register. One compare value sets the duty cycle. The waveform level is cleared when the counter meets the compare value on the way up and set when it meets it on the way down. The polarity can be inverted, and the pin can be disconnected.

Writes to the compare value and to the limit register go to holding registers. Both are copied into the active copies when the counter arrives at the turning value, so a period is never cut short. When the counter arrives at the turning value, the waveform is forced to the level that a rising match would give. This keeps the waveform symmetric around zero even when no match took place on the way up. Two sticky flags report arrival at zero and compare hits. Each flag is cleared by its own write-one input.

Top module: `pcpwm_timer`

## Requirements
- R1: The counter steps by one per enable. It rises to TOP, holds TOP for one step and then falls, and it holds 0 for one step and then rises. A full period is 2×TOP enables, which is 510 for TOP = 255.
- R2: With `top_sel_i` = 0, TOP is 255. With `top_sel_i` = 1, TOP is the active limit register. A limit of 0x10 then gives a 32-step period, and the counter never exceeds 0x10 once it has dropped below that value.
- R3: `ps_sel_i` picks the enable rate. Code 0 stops the counter, and codes 1 to 7 give one enable every 1, 8, 32, 64, 128, 256 or 1024 clocks. With `en_i` low, the counter holds its value.
- R4: In non-inverting mode (`mode_i` = 2), a compare hit while rising drives the level low and a compare hit while falling drives it high. Inverting mode (`mode_i` = 3) drives the complementary level.
- R5: A compare value of 0 gives a constant low level. A compare value at or above TOP gives a constant high level. Both levels are reversed in inverting mode.
- R6: When the counter arrives at TOP, the level is forced to the rising-match result: low if compare < TOP, high otherwise. This holds even when no match occurred during the rise.
- R7: Compare and limit writes go to holding registers. These are copied into the active registers only on the step that arrives at TOP.
- R8: `pin_oe_o` is high only when `pin_dir_i` = 1 and `mode_i` is 2 or 3. While `pin_oe_o` is low, `pin_o` is 0.
- R9: `ovf_o` is set on the step that brings the counter down to 0. It stays set until a one on `ovf_clr_i`, and a set in the same cycle wins.
- R10: `cmp_flag_o` is set on each step whose new count equals the active compare value. It stays set until a one on `cmp_clr_i`.
- R11: While `rst_ni` is low, the count is 0, the direction is up, both flags are 0, the level is low and the active compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable; gates prescaler and counter |
| ps_sel_i | input | 3 | Prescale code (0 stop, 1..7 = 1,8,32,64,128,256,1024) |
| cmp_wr_i | input | 1 | Write strobe for compare holding register |
| cmp_data_i | input | 8 | Compare write data |
| top_wr_i | input | 1 | Write strobe for limit holding register |
| top_data_i | input | 8 | Limit write data |
| top_sel_i | input | 1 | 0: TOP = 255, 1: TOP = active limit |
| mode_i | input | 2 | 0/1 disconnected, 2 non-inverting, 3 inverting |
| pin_dir_i | input | 1 | Pin direction, 1 = output |
| ovf_clr_i | input | 1 | Write-one clear of the bottom flag |
| cmp_clr_i | input | 1 | Write-one clear of the compare flag |
| cnt_o | output | 8 | Current count |
| pin_o | output | 1 | Waveform pin value |
| pin_oe_o | output | 1 | Pin output enable (low = high impedance) |
| ovf_o | output | 1 | Bottom-reached flag |
| cmp_flag_o | output | 1 | Compare-hit flag |

## Verification
The waveform is swept over a table of compare values and both polarities, and every count and pin level of a full 510-step period is compared against the triangle and threshold rule. The compare values 0 and 255 separate the constant-level cases from ordinary threshold behaviour. The value 254 separates a match on the falling side from a match on the rising side next to TOP. A step from 255 down to 0x40 exposes a missing forced transition at TOP. A compare change made in mid-rise, sampled once before and once after the next TOP, separates buffered from immediate loading. A limit register below the compare value checks the short period and the constant-high level together.

// File: rtl/pcpwm_pkg.sv
`timescale 1ns/1ps
package pcpwm_pkg;
  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_RSVD   = 2'd1,
    PIN_NONINV = 2'd2,
    PIN_INV    = 2'd3
  } pin_mode_e;

  // log2 of the divide ratio per prescale code; code 0 is stopped
  function automatic int unsigned ps_shift(input logic [2:0] code);
    case (code)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
`timescale 1ns/1ps
module pcpwm_prescaler #(
  parameter int PS_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import pcpwm_pkg::*;

  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (en_i) div_q <= div_q + PS_W'(1);
  end

  always_comb begin
    mask = (PS_W'(1) << ps_shift(sel_i)) - PS_W'(1);
  end

  assign tick_o = en_i && (sel_i != 3'd0) && ((div_q & mask) == mask);
endmodule

// File: rtl/pcpwm_counter.sv
`timescale 1ns/1ps
module pcpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         up_o,
  output logic         step_up_o,
  output logic         arr_top_o,
  output logic         arr_bot_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;
  logic         top_hit, bot_hit;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    top_hit = 1'b0;
    bot_hit = 1'b0;
    if (up_q) begin
      if (cnt_q >= top_i) begin
        if (cnt_q == '0) begin
          top_hit = 1'b1;                 // TOP of zero: park at 0
        end else begin
          cnt_d = cnt_q - W'(1);          // turn after one step at TOP
          up_d  = 1'b0;
        end
      end else begin
        cnt_d   = cnt_q + W'(1);
        top_hit = (cnt_d == top_i);
      end
    end else begin
      if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = (top_i == '0) ? '0 : W'(1);
      end else begin
        cnt_d   = cnt_q - W'(1);
        bot_hit = (cnt_d == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign nxt_o     = cnt_d;
  assign up_o      = up_q;
  assign step_up_o = up_d;
  assign arr_top_o = tick_i & top_hit;
  assign arr_bot_o = tick_i & bot_hit;
endmodule

// File: rtl/pcpwm_regbuf.sv
`timescale 1ns/1ps
module pcpwm_regbuf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_data_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_data_i,
  input  logic         load_i,
  output logic [W-1:0] cmp_nxt_o,
  output logic [W-1:0] cmp_act_o,
  output logic [W-1:0] top_act_o
);
  logic [W-1:0] cmp_buf_q, top_buf_q;
  logic [W-1:0] cmp_act_q, top_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_buf_q <= '0;
      top_buf_q <= '1;
    end else begin
      if (cmp_wr_i) cmp_buf_q <= cmp_data_i;
      if (top_wr_i) top_buf_q <= top_data_i;
    end
  end

  // a write in the load cycle lands in the holding register only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_act_q <= '0;
      top_act_q <= '1;
    end else if (load_i) begin
      cmp_act_q <= cmp_buf_q;
      top_act_q <= top_buf_q;
    end
  end

  assign cmp_nxt_o = load_i ? cmp_buf_q : cmp_act_q;
  assign cmp_act_o = cmp_act_q;
  assign top_act_o = top_act_q;
endmodule

// File: rtl/pcpwm_wave.sv
`timescale 1ns/1ps
module pcpwm_wave #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         arr_top_i,
  input  logic         step_up_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] top_i,
  output logic         wave_o
);
  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (tick_i) begin
      if (arr_top_i) begin
        // forced rising-match level keeps symmetry around BOTTOM
        wave_d = (cmp_i >= top_i);
      end else if (nxt_i == cmp_i) begin
        wave_d = (cmp_i == '0) ? 1'b0 : !step_up_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/pcpwm_flags.sv
`timescale 1ns/1ps
module pcpwm_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         arr_bot_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         ovf_clr_i,
  input  logic         cmp_clr_i,
  output logic         ovf_o,
  output logic         cmp_o
);
  logic ovf_q, cmp_q;
  logic hit;

  assign hit = tick_i && (nxt_i == cmp_i);

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      if (arr_bot_i)      ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
      if (hit)            cmp_q <= 1'b1;
      else if (cmp_clr_i) cmp_q <= 1'b0;
    end
  end

  assign ovf_o = ovf_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/pcpwm_timer.sv
`timescale 1ns/1ps
module pcpwm_timer #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       ps_sel_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             top_wr_i,
  input  logic [CNT_W-1:0] top_data_i,
  input  logic             top_sel_i,
  input  logic [1:0]       mode_i,
  input  logic             pin_dir_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             ovf_o,
  output logic             cmp_flag_o
);
  import pcpwm_pkg::*;

  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_up, step_up, arr_top, arr_bot;
  logic [CNT_W-1:0] cmp_nxt, cmp_act, top_act, top_cur;
  logic             wave_q, level;
  pin_mode_e        mode;

  assign mode    = pin_mode_e'(mode_i);
  assign top_cur = top_sel_i ? top_act : '1;

  pcpwm_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (ps_sel_i),
    .tick_o (tick)
  );

  pcpwm_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .top_i     (top_cur),
    .cnt_o     (cnt_q),
    .nxt_o     (cnt_nxt),
    .up_o      (cnt_up),
    .step_up_o (step_up),
    .arr_top_o (arr_top),
    .arr_bot_o (arr_bot)
  );

  pcpwm_regbuf #(.W(CNT_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .top_wr_i   (top_wr_i),
    .top_data_i (top_data_i),
    .load_i     (arr_top),
    .cmp_nxt_o  (cmp_nxt),
    .cmp_act_o  (cmp_act),
    .top_act_o  (top_act)
  );

  pcpwm_wave #(.W(CNT_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .arr_top_i (arr_top),
    .step_up_i (step_up),
    .nxt_i     (cnt_nxt),
    .cmp_i     (cmp_nxt),
    .top_i     (top_cur),
    .wave_o    (wave_q)
  );

  pcpwm_flags #(.W(CNT_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .arr_bot_i (arr_bot),
    .nxt_i     (cnt_nxt),
    .cmp_i     (cmp_nxt),
    .ovf_clr_i (ovf_clr_i),
    .cmp_clr_i (cmp_clr_i),
    .ovf_o     (ovf_o),
    .cmp_o     (cmp_flag_o)
  );

  assign level    = (mode == PIN_INV) ? ~wave_q : wave_q;
  assign pin_oe_o = pin_dir_i && ((mode == PIN_NONINV) || (mode == PIN_INV));
  assign pin_o    = pin_oe_o & level;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/pcpwm_checker.sv
`timescale 1ns/1ps
module pcpwm_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic         up,
  input logic [W-1:0] cmp_act,
  input logic         wave,
  input logic         pin_o,
  input logic         pin_oe_o,
  input logic         ovf_o
);
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt));

  a_r1_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ((cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1)) || (cnt == $past(cnt))));

  a_r9_bottom_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !up && (cnt == W'(1))) |=> ovf_o);

  a_r8_pin_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);

  a_r5_zero_compare_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_act == '0) |-> !wave);
endmodule

bind pcpwm_timer pcpwm_checker #(.W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .cnt      (cnt_q),
  .up       (cnt_up),
  .cmp_act  (cmp_act),
  .wave     (wave_q),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .ovf_o    (ovf_o)
);

// File: tb/pcpwm_timer_bench.sv
`timescale 1ns/1ps
module pcpwm_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [2:0] ps_sel_i = 3'd1;
  logic       cmp_wr_i = 1'b0;
  logic [7:0] cmp_data_i = 8'h00;
  logic       top_wr_i = 1'b0;
  logic [7:0] top_data_i = 8'h00;
  logic       top_sel_i = 1'b0;
  logic [1:0] mode_i = 2'd2;
  logic       pin_dir_i = 1'b1;
  logic       ovf_clr_i = 1'b0;
  logic       cmp_clr_i = 1'b0;
  logic [7:0] cnt_o;
  logic       pin_o, pin_oe_o, ovf_o, cmp_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pcpwm_timer u_pcpwm_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ps_sel_i   (ps_sel_i),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .top_wr_i   (top_wr_i),
    .top_data_i (top_data_i),
    .top_sel_i  (top_sel_i),
    .mode_i     (mode_i),
    .pin_dir_i  (pin_dir_i),
    .ovf_clr_i  (ovf_clr_i),
    .cmp_clr_i  (cmp_clr_i),
    .cnt_o      (cnt_o),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .ovf_o      (ovf_o),
    .cmp_flag_o (cmp_flag_o)
  );

  // {mode, compare}; FF followed by 40 exercises the forced level at TOP
  localparam logic [9:0] VEC [9] = '{
    {2'd2, 8'h00}, {2'd3, 8'h00}, {2'd2, 8'h01}, {2'd3, 8'h80}, {2'd2, 8'hFE},
    {2'd2, 8'hFF}, {2'd2, 8'h40}, {2'd3, 8'hFF}, {2'd2, 8'h40}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    int g = 0;
    do begin
      @(negedge clk_i);
      g++;
    end while (cnt_o != v && g < 4000);
    if (g >= 4000) check(1'b0, "R1 count never reached", int'(cnt_o), int'(v));
  endtask

  task automatic measure_gap(output int k);
    logic [7:0] c0;
    int g = 0;
    c0 = cnt_o;
    do begin @(negedge clk_i); g++; end while (cnt_o == c0 && g < 5000);
    k = 0;
    c0 = cnt_o;
    do begin @(negedge clk_i); k++; end while (cnt_o == c0 && k < 5000);
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_data_i = v;
    cmp_wr_i = 1'b1;
    @(negedge clk_i);
    cmp_wr_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    int errs;
    int ea, ee;
    logic [7:0] c;
    logic [1:0] m;
    logic [7:0] mx;
    bit hi_all;

    // R11 reset state
    repeat (3) @(negedge clk_i);
    check(cnt_o == 8'h00, "R11 count in reset", int'(cnt_o), 0);
    check(ovf_o == 1'b0, "R11 bottom flag in reset", int'(ovf_o), 0);
    check(cmp_flag_o == 1'b0, "R11 compare flag in reset", int'(cmp_flag_o), 0);
    check(pin_o == 1'b0, "R11 pin low in reset", int'(pin_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cnt_o == 8'h01, "R11 first step counts up", int'(cnt_o), 1);

    // R3 prescaler rates and stop
    ps_sel_i = 3'd2;
    measure_gap(k);
    check(k == 8, "R3 divide by 8", k, 8);
    ps_sel_i = 3'd4;
    measure_gap(k);
    check(k == 64, "R3 divide by 64", k, 64);
    ps_sel_i = 3'd7;
    measure_gap(k);
    check(k == 1024, "R3 divide by 1024", k, 1024);
    ps_sel_i = 3'd0;
    @(negedge clk_i);
    c = cnt_o;
    repeat (300) @(negedge clk_i);
    check(cnt_o == c, "R3 code 0 stops counter", int'(cnt_o), int'(c));
    ps_sel_i = 3'd1;
    en_i = 1'b0;
    @(negedge clk_i);
    c = cnt_o;
    repeat (50) @(negedge clk_i);
    check(cnt_o == c, "R3 enable low holds counter", int'(cnt_o), int'(c));
    en_i = 1'b1;

    // R1 R4 R5 R6 R7: table of compare/mode, full period each
    for (int v = 0; v < 9; v++) begin
      m = VEC[v][9:8];
      c = VEC[v][7:0];
      mode_i = m;
      wr_cmp(c);
      wait_cnt(8'd254);
      wait_cnt(8'd255);
      errs = 0;
      ea = 0;
      ee = 0;
      for (int i = 0; i < 510; i++) begin
        int e;
        bit dn, lvl, ep;
        if (i > 0) @(negedge clk_i);
        e  = (i <= 255) ? 255 - i : i - 255;
        dn = (i > 0) && (i <= 255);
        if (c == 8'h00)   lvl = 1'b0;
        else if (e == 255) lvl = (int'(c) >= 255);
        else               lvl = (e < int'(c)) || (e == int'(c) && dn);
        ep = (m == 2'd3) ? !lvl : lvl;
        if (int'(cnt_o) != e && errs == 0) begin ea = int'(cnt_o); ee = e; end
        if (int'(cnt_o) != e) errs++;
        if (pin_o != ep) begin
          if (errs == 0) begin ea = 1000 + int'(pin_o); ee = 1000 + int'(ep); end
          errs++;
        end
      end
      // R1 triangle, R4 polarity, R5 extremes, R6 forced level at 255
      check(errs == 0, $sformatf("R1 R4 R5 R6 period vector %0d", v), ea, ee);
      check(pin_oe_o == 1'b1, $sformatf("R8 enabled vector %0d", v), int'(pin_oe_o), 1);
    end

    // R1 period length between bottoms
    wait_cnt(8'd0);
    k = 0;
    do begin @(negedge clk_i); k++; end while (cnt_o != 8'd0 && k < 2000);
    check(k == 510, "R1 period 510 enables", k, 510);

    // R7 compare buffering: active 0x40, write 0x20 on the way up
    wait_cnt(8'd0);
    wait_cnt(8'h10);
    wr_cmp(8'h20);
    wait_cnt(8'h30);
    check(pin_o == 1'b1, "R7 old compare still active before TOP", int'(pin_o), 1);
    wait_cnt(8'hFF);
    wait_cnt(8'h30);
    check(pin_o == 1'b0, "R7 new compare active after TOP", int'(pin_o), 0);

    // R9 bottom flag
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
    check(ovf_o == 1'b0, "R9 clear", int'(ovf_o), 0);
    wait_cnt(8'd0);
    check(ovf_o == 1'b1, "R9 set at bottom", int'(ovf_o), 1);
    repeat (20) @(negedge clk_i);
    check(ovf_o == 1'b1, "R9 sticky", int'(ovf_o), 1);
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
    check(ovf_o == 1'b0, "R9 clear after sticky", int'(ovf_o), 0);

    // R10 compare flag with active compare 0x20
    wait_cnt(8'h05);
    cmp_clr_i = 1'b1;
    @(negedge clk_i);
    cmp_clr_i = 1'b0;
    check(cmp_flag_o == 1'b0, "R10 clear", int'(cmp_flag_o), 0);
    wait_cnt(8'h1F);
    check(cmp_flag_o == 1'b0, "R10 no hit below compare", int'(cmp_flag_o), 0);
    wait_cnt(8'h20);
    check(cmp_flag_o == 1'b1, "R10 set on hit", int'(cmp_flag_o), 1);

    // R8 pin enable
    mode_i = 2'd0;
    #1;
    check(pin_oe_o == 1'b0 && pin_o == 1'b0, "R8 mode 0 disconnected", int'({pin_oe_o, pin_o}), 0);
    mode_i = 2'd1;
    #1;
    check(pin_oe_o == 1'b0 && pin_o == 1'b0, "R8 mode 1 disconnected", int'({pin_oe_o, pin_o}), 0);
    mode_i = 2'd3;
    pin_dir_i = 1'b0;
    #1;
    check(pin_oe_o == 1'b0 && pin_o == 1'b0, "R8 direction input", int'({pin_oe_o, pin_o}), 0);
    pin_dir_i = 1'b1;
    mode_i = 2'd2;

    // R2 limit register 0x10 with compare 0x20 above it
    top_data_i = 8'h10;
    top_wr_i = 1'b1;
    @(negedge clk_i);
    top_wr_i = 1'b0;
    wait_cnt(8'd254);
    wait_cnt(8'd255);
    top_sel_i = 1'b1;
    wait_cnt(8'd0);
    k = 0;
    mx = 8'd0;
    hi_all = 1'b1;
    do begin
      @(negedge clk_i);
      k++;
      if (cnt_o > mx) mx = cnt_o;
      if (!pin_o) hi_all = 1'b0;
    end while (cnt_o != 8'd0 && k < 2000);
    check(k == 32, "R2 period with limit 0x10", k, 32);
    check(mx == 8'h10, "R2 peak equals limit", int'(mx), 16);
    check(hi_all, "R5 compare above TOP stays high", int'(hi_all), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule